// File: doc/BRIEF.md
# Multi-Accumulator Multiply-Accumulate Datapath

This block is the multiply-accumulate datapath of a DSP core. It holds four 40-bit signed accumulators and takes two 16-bit two's complement operands per cycle. A 4-bit opcode from the instruction decoder chooses the operation, and three 2-bit selects name the destination accumulator and two source accumulators. The available operations are clearing, multiplying, multiply-accumulate, accumulator sum and difference, absolute value, and scaling. Another operation adds a scaled copy of the first operand, placed in the top 16 bits of a 40-bit word, to an accumulator. A final operation converts an accumulator to a rounded, saturated 16-bit value for the register file.

The second operand controls scaling at run time. Read as an unsigned count `s` and limited to at most 24, it selects an arithmetic right shift by `24 - s` bits. With `s = 24` the value passes unchanged. With `s = 0` it is divided by 2^24. The readout rounds at the position the shift selects: it adds the last bit shifted out. Accumulator arithmetic wraps at 40 bits. Only the readout saturates.

Top module: `mac_unit`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, all four accumulators and `rf_out` are cleared to zero.
- R2: Opcode 1 writes zero to accumulator `dst_sel`. Opcode 2 writes the signed 32-bit product `op_a*op_b`, sign-extended to 40 bits.
- R3: Opcode 3 writes `acc[srca_sel] + op_a*op_b`. Opcode 4 writes `acc[srca_sel] + acc[srcb_sel]`. Opcode 5 writes `acc[srca_sel] - acc[srcb_sel]`. All three wrap modulo 2^40.
- R4: Opcode 6 writes the absolute value of `acc[srca_sel]`. The most negative value 0x80_0000_0000 is written back unchanged.
- R5: Opcode 7 writes `acc[srca_sel]` arithmetically shifted right by `24 - s`. Here `s` is `op_b` read as unsigned, and any value above 24 counts as 24.
- R6: Opcode 8 writes `acc[srca_sel] + ({op_a, 24'b0} >>> (24 - s))`, where the 40-bit word is signed and `s` is clamped as in R5.
- R7: Opcode 9 loads `rf_out` at the clock edge. The value is `acc[srca_sel] >>> (24 - s)`, plus bit `23 - s` of `acc[srca_sel]` when the shift is nonzero, reduced to 16 bits.
- R8: If the rounded readout value is above 32767, `rf_out` becomes 0x7FFF. If it is below -32768, `rf_out` becomes 0x8000.
- R9: Opcodes 0 and 9, and the unused opcodes 10 to 15, write no accumulator. `rf_out` changes only on opcode 9.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| op_code | input | 4 | Operation select |
| dst_sel | input | 2 | Destination accumulator |
| srca_sel | input | 2 | First source accumulator |
| srcb_sel | input | 2 | Second source accumulator |
| op_a | input | 16 | First operand, signed |
| op_b | input | 16 | Second operand, signed for products, unsigned scale count otherwise |
| rf_out | output | 16 | Registered rounded, saturated readout |

## Verification
The bench builds the block with its default parameters: 16-bit operands, 40-bit accumulators, four accumulators and a scale range of 24. At these widths the bench can reach every corner it targets. These include a product of two most-negative operands, an accumulator sum that wraps past bit 39, and the most negative accumulator value under absolute value. They also include rounding of odd values of both signs, and scale counts clamped from 30 and from 0x8000. Each accumulator is read back through the opcode-9 readout at several scale counts. This exposes the high and low parts of the 40-bit value.

// File: rtl/mac_pkg.sv
// mac_pkg: opcode encoding shared by the multiply-accumulate datapath.
// Assumes a 4-bit opcode field from the decoder.
package mac_pkg;
    localparam int OPC_W = 4;

    typedef enum logic [OPC_W-1:0] {
        MOP_IDLE   = 4'd0,
        MOP_ZERO   = 4'd1,
        MOP_MUL    = 4'd2,
        MOP_MAC    = 4'd3,
        MOP_ADD    = 4'd4,
        MOP_SUB    = 4'd5,
        MOP_ABS    = 4'd6,
        MOP_SCL    = 4'd7,
        MOP_ADDSCL = 4'd8,
        MOP_RDOUT  = 4'd9
    } mac_op_e;
endpackage

// File: rtl/mac_acc_file.sv
// mac_acc_file: bank of wide accumulators with one write port and two
// combinational read ports. Assumes synchronous active-low reset.
// A read during a write to the same entry returns the old value.
module mac_acc_file #(
    parameter int NACC  = 4,
    parameter int ACC_W = 40,
    localparam int SEL_W = $clog2(NACC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [ACC_W-1:0] wr_data,
    input  logic [SEL_W-1:0] rda_sel,
    input  logic [SEL_W-1:0] rdb_sel,
    output logic [ACC_W-1:0] rda_data,
    output logic [ACC_W-1:0] rdb_data
);
    logic [ACC_W-1:0] acc_q [NACC];

    // Clears on reset, otherwise stores the write data into the chosen entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NACC; i++) acc_q[i] <= '0;
        end else if (wr_en) begin
            acc_q[wr_sel] <= wr_data;
        end
    end

    // Drives both read ports from the current contents.
    always_comb begin
        rda_data = acc_q[rda_sel];
        rdb_data = acc_q[rdb_sel];
    end
endmodule

// File: rtl/mac_scaler.sv
// mac_scaler: arithmetic right shift of a signed wide word by a run-time
// amount. With WITH_ROUND set, it also returns the last bit shifted out
// (zero when the shift amount is zero). Assumes sh_amt < ACC_W.
module mac_scaler #(
    parameter int ACC_W      = 40,
    parameter bit WITH_ROUND = 1'b1,
    localparam int SH_W = $clog2(ACC_W)
) (
    input  logic [ACC_W-1:0] din,
    input  logic [SH_W-1:0]  sh_amt,
    output logic [ACC_W-1:0] dout,
    output logic             rnd_bit
);
    // Performs the sign-preserving shift.
    always_comb dout = ACC_W'($signed(din) >>> sh_amt);

    generate
        if (WITH_ROUND) begin : g_rnd
            // Picks the bit just below the new least significant bit.
            always_comb rnd_bit = (sh_amt == '0) ? 1'b0 : din[sh_amt - SH_W'(1)];
        end else begin : g_nornd
            // No rounding needed for this instance.
            always_comb rnd_bit = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/mac_sat.sv
// mac_sat: reduces a signed wide word to OUT_W bits. Values outside the
// narrow range clamp to the largest positive or most negative code.
module mac_sat #(
    parameter int ACC_W = 40,
    parameter int OUT_W = 16
) (
    input  logic [ACC_W-1:0] din,
    output logic [OUT_W-1:0] dout
);
    logic sgn;
    logic ovf;

    // Detects upper bits that are not all copies of the sign.
    always_comb begin
        sgn = din[ACC_W-1];
        ovf = din[ACC_W-2:OUT_W-1] != {(ACC_W-OUT_W){sgn}};
    end

    // Selects the clamp code or the low bits.
    always_comb begin
        if (!ovf)     dout = din[OUT_W-1:0];
        else if (sgn) dout = {1'b1, {(OUT_W-1){1'b0}}};
        else          dout = {1'b0, {(OUT_W-1){1'b1}}};
    end
endmodule

// File: rtl/mac_unit.sv
// mac_unit: multiply-accumulate datapath with NACC accumulators.
// Assumes the decoder holds op_code and the selects stable around the
// rising edge. Results land in the accumulator file at that edge. The
// readout is a registered rounded, saturated view of one accumulator.
module mac_unit #(
    parameter int OP_W      = 16,
    parameter int ACC_W     = 40,
    parameter int NACC      = 4,
    parameter int SCALE_MAX = 24,
    localparam int SEL_W  = $clog2(NACC),
    localparam int SH_W   = $clog2(ACC_W),
    localparam int PROD_W = 2 * OP_W
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [mac_pkg::OPC_W-1:0]    op_code,
    input  logic [SEL_W-1:0]             dst_sel,
    input  logic [SEL_W-1:0]             srca_sel,
    input  logic [SEL_W-1:0]             srcb_sel,
    input  logic [OP_W-1:0]              op_a,
    input  logic [OP_W-1:0]              op_b,
    output logic [OP_W-1:0]              rf_out
);
    import mac_pkg::*;

    mac_op_e          opc;
    logic [SH_W-1:0]  cnt_clamped;
    logic [SH_W-1:0]  sh_amt;
    logic [PROD_W-1:0] prod;
    logic [ACC_W-1:0] prod_ext;
    logic [ACC_W-1:0] rd_y;
    logic [ACC_W-1:0] rd_z;
    logic [ACC_W-1:0] scl_y;
    logic [ACC_W-1:0] scl_a;
    logic             rnd_y;
    logic             rnd_a_unused;
    logic [ACC_W-1:0] rounded;
    logic [OP_W-1:0]  sat_val;
    logic [ACC_W-1:0] wr_data;
    logic             wr_en;
    logic [OP_W-1:0]  rf_q;

    // Decodes the opcode and derives the shift from the clamped count.
    always_comb begin
        opc         = mac_op_e'(op_code);
        cnt_clamped = (op_b > OP_W'(SCALE_MAX)) ? SH_W'(SCALE_MAX) : op_b[SH_W-1:0];
        sh_amt      = SH_W'(SCALE_MAX) - cnt_clamped;
    end

    // Forms the signed product and widens it to accumulator width.
    always_comb begin
        prod     = PROD_W'($signed(op_a) * $signed(op_b));
        prod_ext = {{(ACC_W-PROD_W){prod[PROD_W-1]}}, prod};
    end

    mac_acc_file #(.NACC(NACC), .ACC_W(ACC_W)) u_acc (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_sel   (dst_sel),
        .wr_data  (wr_data),
        .rda_sel  (srca_sel),
        .rdb_sel  (srcb_sel),
        .rda_data (rd_y),
        .rdb_data (rd_z)
    );

    mac_scaler #(.ACC_W(ACC_W), .WITH_ROUND(1'b1)) u_scl_acc (
        .din     (rd_y),
        .sh_amt  (sh_amt),
        .dout    (scl_y),
        .rnd_bit (rnd_y)
    );

    mac_scaler #(.ACC_W(ACC_W), .WITH_ROUND(1'b0)) u_scl_opa (
        .din     ({op_a, {(ACC_W-OP_W){1'b0}}}),
        .sh_amt  (sh_amt),
        .dout    (scl_a),
        .rnd_bit (rnd_a_unused)
    );

    // Adds the rounding bit. A shifted value has headroom, so no carry is lost.
    always_comb rounded = scl_y + ACC_W'(rnd_y);

    mac_sat #(.ACC_W(ACC_W), .OUT_W(OP_W)) u_sat (
        .din  (rounded),
        .dout (sat_val)
    );

    // Selects the accumulator write value for each opcode.
    always_comb begin
        wr_en   = 1'b1;
        wr_data = '0;
        unique case (opc)
            MOP_ZERO:   wr_data = '0;
            MOP_MUL:    wr_data = prod_ext;
            MOP_MAC:    wr_data = rd_y + prod_ext;
            MOP_ADD:    wr_data = rd_y + rd_z;
            MOP_SUB:    wr_data = rd_y - rd_z;
            MOP_ABS:    wr_data = rd_y[ACC_W-1] ? (~rd_y + ACC_W'(1)) : rd_y;
            MOP_SCL:    wr_data = scl_y;
            MOP_ADDSCL: wr_data = rd_y + scl_a;
            default:    wr_en   = 1'b0;
        endcase
    end

    // Holds the register-file readout and updates it on the readout opcode.
    always_ff @(posedge clk) begin
        if (!rst_n)                rf_q <= '0;
        else if (opc == MOP_RDOUT) rf_q <= sat_val;
    end

    assign rf_out = rf_q;
endmodule

// File: rtl/mac_unit_chk.sv
// mac_unit_chk: temporal checks on mac_unit, attached by bind. It sees the
// first read port and the readout register and relates them over time.
module mac_unit_chk #(
    parameter int OP_W      = 16,
    parameter int ACC_W     = 40,
    parameter int SEL_W     = 2,
    parameter int SCALE_MAX = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic [3:0]       op_code,
    input logic [SEL_W-1:0] dst_sel,
    input logic [SEL_W-1:0] srca_sel,
    input logic [OP_W-1:0]  op_b,
    input logic [ACC_W-1:0] rd_y,
    input logic [OP_W-1:0]  rf_out
);
    logic full_cnt;
    logic big_pos;
    logic big_neg;

    // Flags readouts with no shift and an accumulator beyond 16-bit range.
    always_comb begin
        full_cnt = op_b >= OP_W'(SCALE_MAX);
        big_pos  = !rd_y[ACC_W-1] && (rd_y > ACC_W'(32767));
        big_neg  = rd_y[ACC_W-1] && ($signed(rd_y) < -ACC_W'(32768));
    end

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> rf_out == '0); // R1

    AST_ZERO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        op_code == 4'd1 |=> (srca_sel != $past(dst_sel) || rd_y == '0)); // R2

    AST_POS_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == 4'd9 && full_cnt && big_pos) |=> rf_out == 16'h7FFF); // R8

    AST_NEG_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == 4'd9 && full_cnt && big_neg) |=> rf_out == 16'h8000); // R8

    AST_RF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        op_code != 4'd9 |=> $stable(rf_out)); // R9

    AST_NO_ACC_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == 4'd0 || op_code == 4'd9 || op_code > 4'd9)
        |=> (srca_sel != $past(srca_sel) || rd_y == $past(rd_y))); // R9
endmodule

bind mac_unit mac_unit_chk #(
    .OP_W(OP_W), .ACC_W(ACC_W), .SEL_W(SEL_W), .SCALE_MAX(SCALE_MAX)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_code  (op_code),
    .dst_sel  (dst_sel),
    .srca_sel (srca_sel),
    .op_b     (op_b),
    .rd_y     (rd_y),
    .rf_out   (rf_out)
);

// File: tb/sim_mac_unit.sv
// sim_mac_unit: directed bench with a reference model of the accumulators.
module sim_mac_unit;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  op_code = '0;
    logic [1:0]  dst_sel = '0;
    logic [1:0]  srca_sel = '0;
    logic [1:0]  srcb_sel = '0;
    logic [15:0] op_a = '0;
    logic [15:0] op_b = '0;
    logic [15:0] rf_out;

    logic [39:0] mdl [4];
    logic [15:0] mdl_rf;
    int n_chk = 0;
    int n_bad = 0;
    bit reported = 0;

    mac_unit u0 (
        .clk(clk), .rst_n(rst_n), .op_code(op_code), .dst_sel(dst_sel),
        .srca_sel(srca_sel), .srcb_sel(srcb_sel), .op_a(op_a), .op_b(op_b),
        .rf_out(rf_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int shift_of(input logic [15:0] b);
        return 24 - ((b > 16'd24) ? 24 : int'(b));
    endfunction

    function automatic logic [39:0] scale40(input logic [39:0] v, input logic [15:0] b);
        longint sv;
        sv = longint'($signed(v)) >>> shift_of(b);
        return sv[39:0];
    endfunction

    function automatic logic [15:0] readout(input logic [39:0] v, input logic [15:0] b);
        longint sv;
        longint t;
        int sh;
        sh = shift_of(b);
        sv = longint'($signed(v));
        t  = sv >>> sh;
        if (sh > 0) t = t + ((sv >>> (sh - 1)) & 64'sd1);
        if (t > 32767)  return 16'h7FFF;
        if (t < -32768) return 16'h8000;
        return t[15:0];
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!reported) begin
            reported = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        end
    endtask

    // Applies one operation for exactly one edge and updates the model.
    task automatic apply(input logic [3:0] op, input int x, input int y, input int z,
                         input logic [15:0] a, input logic [15:0] b);
        logic [39:0] p;
        logic [39:0] nv;
        logic        wr;
        @(negedge clk);
        op_code = op; dst_sel = 2'(x); srca_sel = 2'(y); srcb_sel = 2'(z);
        op_a = a; op_b = b;
        p  = 40'(longint'($signed(a)) * longint'($signed(b)));
        wr = 1'b1;
        nv = '0;
        case (op)
            4'd1: nv = '0;
            4'd2: nv = p;
            4'd3: nv = mdl[y] + p;
            4'd4: nv = mdl[y] + mdl[z];
            4'd5: nv = mdl[y] - mdl[z];
            4'd6: nv = mdl[y][39] ? 40'(0 - mdl[y]) : mdl[y];
            4'd7: nv = scale40(mdl[y], b);
            4'd8: nv = mdl[y] + scale40({a, 24'h0}, b);
            default: wr = 1'b0;
        endcase
        if (op == 4'd9) mdl_rf = readout(mdl[y], b);
        @(negedge clk);
        if (wr) mdl[x] = nv;
        op_code = 4'd0;
    endtask

    task automatic rd_chk(input string tag, input int y, input logic [15:0] b);
        apply(4'd9, 0, y, 0, 16'h0, b);
        check(tag, rf_out, mdl_rf);
    endtask

    task automatic t_reset();
        check("R1 rf_out after reset", rf_out, 16'h0000);
        for (int i = 0; i < 4; i++) rd_chk("R1 accumulator cleared", i, 16'd0);
    endtask

    task automatic t_mul();
        apply(4'd2, 0, 0, 0, 16'sd300, -16'sd7);
        rd_chk("R2 product small", 0, 16'd24);
        check("R2 product value", rf_out, 16'hF7CC);
        apply(4'd2, 1, 0, 0, 16'h8000, 16'h8000);
        rd_chk("R8 positive clamp", 1, 16'd24);
        check("R8 clamp code", rf_out, 16'h7FFF);
        rd_chk("R2 product upper", 1, 16'd8);
        check("R2 product upper value", rf_out, 16'h4000);
        apply(4'd1, 1, 0, 0, 16'h0, 16'h0);
        rd_chk("R2 clear", 1, 16'd24);
    endtask

    task automatic t_arith();
        apply(4'd2, 1, 0, 0, 16'sd1234, 16'sd10);
        apply(4'd3, 2, 1, 0, -16'sd50, 16'sd100);
        rd_chk("R3 multiply-accumulate", 2, 16'd24);
        apply(4'd4, 3, 1, 2, 16'h0, 16'h0);
        rd_chk("R3 accumulator add", 3, 16'd24);
        apply(4'd5, 3, 0, 2, 16'h0, 16'h0);
        rd_chk("R3 accumulator subtract", 3, 16'd24);
        apply(4'd8, 2, 1, 0, 16'h7FFF, 16'd24);
        apply(4'd4, 3, 2, 2, 16'h0, 16'h0);
        rd_chk("R3 add wraps at 40 bits", 3, 16'd0);
        check("R3 wrapped value", rf_out, 16'hFFFE);
    endtask

    task automatic t_abs();
        apply(4'd2, 0, 0, 0, -16'sd25, 16'sd4);
        apply(4'd6, 1, 0, 0, 16'h0, 16'h0);
        rd_chk("R4 abs of negative", 1, 16'd24);
        check("R4 abs value", rf_out, 16'd100);
        apply(4'd1, 2, 0, 0, 16'h0, 16'h0);
        apply(4'd8, 2, 2, 0, 16'h8000, 16'd24);
        apply(4'd6, 3, 2, 0, 16'h0, 16'h0);
        rd_chk("R4 abs of most negative", 3, 16'd0);
        check("R4 most negative kept", rf_out, 16'h8000);
        rd_chk("R8 negative clamp", 3, 16'd24);
    endtask

    task automatic t_scale();
        apply(4'd2, 0, 0, 0, 16'sd12345, 16'sd1000);
        apply(4'd7, 1, 0, 0, 16'h0, 16'd14);
        rd_chk("R5 scale by 2^10", 1, 16'd24);
        apply(4'd7, 1, 0, 0, 16'h0, 16'd30);
        rd_chk("R5 count 30 clamps to 24", 1, 16'd24);
        apply(4'd7, 2, 0, 0, 16'h0, 16'h8000);
        rd_chk("R5 count 0x8000 clamps to 24", 2, 16'd24);
        apply(4'd2, 0, 0, 0, -16'sd3000, 16'sd3000);
        apply(4'd7, 3, 0, 0, 16'h0, 16'd0);
        rd_chk("R5 divide by 2^24", 3, 16'd24);
        apply(4'd8, 3, 0, 0, 16'sd100, 16'd4);
        rd_chk("R6 add scaled operand", 3, 16'd24);
        apply(4'd8, 3, 3, 0, -16'sd3, 16'd20);
        rd_chk("R6 add scaled negative operand", 3, 16'd20);
    endtask

    task automatic t_round();
        apply(4'd2, 0, 0, 0, 16'sd3, 16'sd1);
        rd_chk("R7 round up positive", 0, 16'd23);
        check("R7 round positive value", rf_out, 16'd2);
        apply(4'd2, 0, 0, 0, -16'sd3, 16'sd1);
        rd_chk("R7 round negative", 0, 16'd23);
        check("R7 round negative value", rf_out, 16'hFFFF);
        apply(4'd2, 1, 0, 0, 16'sd5000, 16'sd4000);
        rd_chk("R7 readout at shift 8", 1, 16'd16);
    endtask

    task automatic t_idle();
        logic [15:0] held;
        held = rf_out;
        apply(4'd0, 1, 1, 0, 16'h1234, 16'h5678);
        check("R9 opcode 0 keeps rf_out", rf_out, held);
        apply(4'd12, 1, 1, 1, 16'h7FFF, 16'h7FFF);
        check("R9 unused opcode keeps rf_out", rf_out, held);
        apply(4'd4, 2, 1, 1, 16'h0, 16'h0);
        check("R9 accumulator op keeps rf_out", rf_out, held);
        rd_chk("R9 accumulator untouched", 1, 16'd16);
        apply(4'd9, 1, 0, 0, 16'h0, 16'd24);
        rd_chk("R9 readout writes no accumulator", 1, 16'd16);
    endtask

    initial begin
        for (int i = 0; i < 4; i++) mdl[i] = '0;
        mdl_rf = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_mul();
        t_arith();
        t_abs();
        t_scale();
        t_round();
        t_idle();
        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        summary();
        $finish;
    end
endmodule